// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Clear-to-Send Gating

This block sends asynchronous serial frames on one output pin. Software writes a byte into a holding buffer and sets the format in a control register. A shift register then sends each frame: a low start bit, the data bits with the least significant first, an optional parity bit, and one or two high stop bits. A baud tick input marks bit boundaries, so every bit lasts one tick period.

The transmitter only decides whether to start a new frame inside an end-of-frame window. This window is open while the shifter is idle and during the final stop bit of a frame. A frame starts when the enable flag is set, the buffer holds data, and, if flow control is selected, the active-low clear-to-send pin is low. Once a frame is on the wire, none of these inputs can stop it. Data written before the window's last tick therefore follows the previous frame with no idle bit between them.

Three outputs report progress. A buffer-empty flag shows that the buffer can take new data. A transmitter-empty flag shows that the line has gone quiet. A one-cycle interrupt pulse fires each time the buffer frees up.

Top module: `uart_tx_flow`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` is 1, `tx_empty` is 1, `tx_irq` is 0, and the control register is all zeros, so the transmitter is disabled.
- R2: A write with `wr_sel`=0 loads the data buffer. A write with `wr_sel`=1 loads the control register, whose bit 0 is the transmit enable. While enable is 0, buffered data is not sent and `buf_empty` stays 0.
- R3: Control bit 1 selects flow control. When it is 0, a frame may start only while `cts_n` is low. When it is 1, `cts_n` has no effect.
- R4: Each frame is a start bit (0), then the data bits LSB first, then the parity bit if control bit 2 is set, then the stop bits (1), and each bit lasts one `baud_tick` period. Control bit 5 set means 7 data bits, otherwise 8. With parity on, control bit 3 = 0 gives even parity and 1 gives odd parity. Control bit 4 set gives two stop bits. `txd` is 1 when idle.
- R5: A buffer write clears `buf_empty` to 0 on the next clock. Moving the buffer into the shift register sets it to 1.
- R6: The start condition is acted on only at a `baud_tick` inside the end-of-frame window (idle or final stop bit). Data written before the final stop bit ends is sent with no idle bit after the previous frame.
- R7: Once a frame has started, clearing the enable flag or raising `cts_n` does not shorten or alter it.
- R8: `tx_empty` goes to 1 one clock after the end-of-frame window opens. It returns to 0 on the clock at which a frame starts.
- R9: `tx_irq` is high for exactly one cycle on each 0-to-1 transition of `buf_empty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = data buffer, 1 = control register |
| wr_data | input | DATA_W | Write data |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| cts_n | input | 1 | Active-low clear-to-send |
| txd | output | 1 | Serial data out |
| buf_empty | output | 1 | Data buffer is free |
| tx_empty | output | 1 | Shifter idle or in its last stop bit (lagged one clock) |
| tx_irq | output | 1 | One-cycle pulse when the buffer frees up |

## Verification
Frames are sent with 8-bit and 7-bit data, with no parity, even parity and odd parity, and with one and two stop bits. This shows whether the framer places the parity and stop bits at the right position for each length and computes parity over the right bits. One pair of frames is written back to back, with the second byte written while the first frame is still shifting out; the idle gap between them must be zero, which separates correct end-of-frame reloading from a reload that waits a bit. In other tests the enable flag is held low, and `cts_n` is held high with flow control on and with it off. In still others, enable is dropped or `cts_n` is raised during a frame. Together these show whether the start gate is sampled at the frame boundary and ignored inside the frame.

// File: rtl/utx_pkg.sv
package utx_pkg;

  localparam int CFG_W = 6;

  // bit 0 enable, 1 pass_cts, 2 par_en, 3 par_odd, 4 two_stop, 5 short_len
  typedef struct packed {
    logic short_len;
    logic two_stop;
    logic par_odd;
    logic par_en;
    logic pass_cts;
    logic enable;
  } utx_cfg_t;

  function automatic utx_cfg_t decode_cfg(input logic [CFG_W-1:0] raw);
    return utx_cfg_t'(raw);
  endfunction

endpackage

// File: rtl/utx_regs.sv
module utx_regs
  import utx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              baud_tick,
  input  logic              cts_n,
  input  logic              frame_end,
  output utx_cfg_t          cfg,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_empty,
  output logic              tx_irq,
  output logic              load
);

  logic buf_wr;
  logic cfg_wr;
  logic start_ok;
  logic buf_empty_nxt;

  assign buf_wr   = wr_en && !wr_sel;
  assign cfg_wr   = wr_en && wr_sel;
  assign start_ok = cfg.enable && !buf_empty && (cfg.pass_cts || !cts_n);
  assign load     = start_ok && frame_end && baud_tick;

  always_comb begin
    buf_empty_nxt = buf_empty;
    if (buf_wr)    buf_empty_nxt = 1'b0;
    else if (load) buf_empty_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg       <= '0;
      buf_data  <= '0;
      buf_empty <= 1'b1;
      tx_irq    <= 1'b0;
    end else begin
      if (cfg_wr) cfg <= decode_cfg(wr_data[CFG_W-1:0]);
      if (buf_wr) buf_data <= wr_data;
      buf_empty <= buf_empty_nxt;
      tx_irq    <= buf_empty_nxt && !buf_empty;
    end
  end

  // R2
  load_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!buf_empty && cfg.enable));

  // R3
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !cfg.pass_cts) |-> !cts_n);

  // R5
  load_frees_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !buf_wr) |=> buf_empty);

  // R5
  write_fills_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |=> !buf_empty);

  // R9
  irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> tx_irq);

  // R9
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);

endmodule

// File: rtl/utx_framer.sv
module utx_framer
  import utx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  utx_cfg_t           cfg,
  input  logic [DATA_W-1:0]  data,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);

  logic [DATA_W-1:0] used;
  logic              par_bit;

  // data bits that belong to the frame for the selected length
  for (genvar g = 0; g < DATA_W; g++) begin : g_used
    if (g == DATA_W - 1) begin : g_top
      assign used[g] = !cfg.short_len;
    end else begin : g_low
      assign used[g] = 1'b1;
    end
  end

  function automatic logic parity_of(input logic [DATA_W-1:0] d,
                                     input logic [DATA_W-1:0] m,
                                     input logic odd);
    return (^(d & m)) ^ odd;
  endfunction

  function automatic logic [CNT_W-1:0] length_of(input utx_cfg_t c);
    int n;
    n = 2 + (c.short_len ? DATA_W - 1 : DATA_W);
    if (c.par_en)   n++;
    if (c.two_stop) n++;
    return CNT_W'(n);
  endfunction

  assign par_bit = parity_of(data, used, cfg.par_odd);
  assign nbits   = length_of(cfg);

  always_comb begin
    int ppos;
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (used[i]) frame[1+i] = data[i];
    end
    ppos = cfg.short_len ? DATA_W : DATA_W + 1;
    if (cfg.par_en) frame[ppos] = par_bit;
  end

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter #(
  parameter int FRAME_W = 12,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               baud_tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   nbits_in,
  output logic               txd,
  output logic               frame_end,
  output logic               tx_empty
);

  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   left;
  logic               busy;
  logic               last_bit;

  assign last_bit  = busy && (left == CNT_W'(1));
  assign frame_end = !busy || last_bit;
  assign txd       = sh[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh       <= '1;
      left     <= '0;
      busy     <= 1'b0;
      tx_empty <= 1'b1;
    end else begin
      if (load) begin
        sh   <= frame_in;
        left <= nbits_in;
        busy <= 1'b1;
      end else if (baud_tick && busy) begin
        if (last_bit) begin
          sh   <= '1;
          left <= '0;
          busy <= 1'b0;
        end else begin
          sh   <= {1'b1, sh[FRAME_W-1:1]};
          left <= left - 1'b1;
        end
      end
      if (load)           tx_empty <= 1'b0;
      else if (frame_end) tx_empty <= 1'b1;
    end
  end

  // R4
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  // R4
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd);

  // R7
  no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_end) |=> busy);

  // R6
  load_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (frame_end && baud_tick));

  // R8
  empty_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frame_end) && !load) |=> tx_empty);

  // R8
  empty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !tx_empty);

endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
  import utx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              baud_tick,
  input  logic              cts_n,
  output logic              txd,
  output logic              buf_empty,
  output logic              tx_empty,
  output logic              tx_irq
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  utx_cfg_t           cfg;
  logic [DATA_W-1:0]  buf_data;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;
  logic               load;
  logic               frame_end;

  utx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .baud_tick (baud_tick),
    .cts_n     (cts_n),
    .frame_end (frame_end),
    .cfg       (cfg),
    .buf_data  (buf_data),
    .buf_empty (buf_empty),
    .tx_irq    (tx_irq),
    .load      (load)
  );

  utx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
    .cfg   (cfg),
    .data  (buf_data),
    .frame (frame),
    .nbits (nbits)
  );

  utx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .load      (load),
    .frame_in  (frame),
    .nbits_in  (nbits),
    .txd       (txd),
    .frame_end (frame_end),
    .tx_empty  (tx_empty)
  );

endmodule

// File: tb/tb_uart_tx_flow.sv
module tb_uart_tx_flow;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       baud_tick = 1'b0;
  logic       cts_n = 1'b1;
  logic       txd, buf_empty, tx_empty, tx_irq;

  int checks = 0;
  int errors = 0;
  int frames_done = 0;
  int irq_cnt = 0;
  int irq_long = 0;
  int last_gap = -1;
  logic [7:0] cur_cfg = '0;

  typedef struct {
    logic [11:0] bits;
    int          len;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  uart_tx_flow dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .baud_tick(baud_tick), .cts_n(cts_n), .txd(txd), .buf_empty(buf_empty),
    .tx_empty(tx_empty), .tx_irq(tx_irq)
  );

  // tick every 8 clocks, driven away from the active edge
  initial begin
    int tcnt = 0;
    forever begin
      @(negedge clk);
      tcnt++;
      baud_tick = (tcnt % 8 == 0);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // expected frame from R4, pushed into the scoreboard queue
  task automatic push_frame(input logic [7:0] d);
    exp_t e;
    int k = 0;
    int ones = 0;
    int n = cur_cfg[5] ? 7 : 8;
    e.bits = '1;
    e.bits[k] = 1'b0; k++;
    for (int i = 0; i < n; i++) begin
      e.bits[k] = d[i]; ones += int'(d[i]); k++;
    end
    if (cur_cfg[2]) begin
      e.bits[k] = (ones % 2 == 1) ^ cur_cfg[3]; k++;
    end
    k++;
    if (cur_cfg[4]) k++;
    e.len = k;
    q.push_back(e);
  endtask

  task automatic write_reg(input logic sel, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_ctrl(input logic [7:0] v);
    cur_cfg = v;
    write_reg(1'b1, v);
  endtask

  task automatic send(input logic [7:0] d);
    push_frame(d);
    write_reg(1'b0, d);
  endtask

  task automatic wait_frames(input int n);
    while (frames_done < n) @(negedge clk);
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (!baud_tick);
  endtask

  task automatic wait_start();
    while (tx_empty) @(negedge clk);
  endtask

  // monitor: samples one bit per tick and compares whole frames (R4)
  initial begin
    logic [11:0] got;
    exp_t e;
    int idx = 0;
    int idle_cnt = 0;
    bit in_frame = 0;
    forever begin
      @(posedge clk);
      if (baud_tick && rst_n) begin
        @(negedge clk);
        if (!in_frame) begin
          if (txd == 1'b0) begin
            if (q.size() == 0) begin
              check(0, "R2", "unexpected frame start", 1, 0);
            end else begin
              e = q.pop_front();
              got = '1; got[0] = 1'b0; idx = 1; in_frame = 1;
              last_gap = idle_cnt; idle_cnt = 0;
            end
          end else begin
            idle_cnt++;
          end
        end else begin
          got[idx] = txd; idx++;
          if (idx == e.len) begin
            logic [11:0] m;
            m = 12'((1 << e.len) - 1);
            check((got & m) == (e.bits & m), "R4", "frame bits",
                  int'(got & m), int'(e.bits & m));
            in_frame = 0;
            frames_done++;
          end
        end
      end
    end
  end

  // R9 pulse monitor
  initial begin
    bit prev = 0;
    forever begin
      @(negedge clk);
      if (tx_irq) irq_cnt++;
      if (tx_irq && prev) irq_long++;
      prev = tx_irq;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", "run did not finish", 0, 1);
    report();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
    check(buf_empty == 1'b1, "R1", "buf_empty after reset", int'(buf_empty), 1);
    check(tx_empty == 1'b1, "R1", "tx_empty after reset", int'(tx_empty), 1);
    check(tx_irq == 1'b0, "R1", "tx_irq after reset", int'(tx_irq), 0);

    // R2: buffered data held while disabled
    set_ctrl(8'h02);
    send(8'hA5);
    check(buf_empty == 1'b0, "R5", "buf_empty after write", int'(buf_empty), 0);
    repeat (40) @(negedge clk);
    check(frames_done == 0 && txd == 1'b1, "R2", "frames while disabled", frames_done, 0);
    check(buf_empty == 1'b0, "R2", "buffer kept while disabled", int'(buf_empty), 0);
    set_ctrl(8'h03);
    wait_frames(1);

    // R4 format variety
    set_ctrl(8'h27); send(8'h5A); wait_frames(2);   // 7 bits even parity
    set_ctrl(8'h1F); send(8'hC3); wait_frames(3);   // 8 bits odd parity 2 stop
    set_ctrl(8'h2F); send(8'h7F); wait_frames(4);   // 7 bits odd parity
    set_ctrl(8'h13); send(8'h01); wait_frames(5);   // 8 bits 2 stop
    set_ctrl(8'h17); send(8'h96); wait_frames(6);   // 8 bits even parity 2 stop

    // R8: tx_empty lags window opening by one clock (8N1: last bit after 9 ticks)
    set_ctrl(8'h03);
    send(8'h81);
    wait_start();
    check(buf_empty == 1'b1, "R5", "buf_empty after load", int'(buf_empty), 1);
    for (int i = 0; i < 9; i++) wait_tick();
    @(negedge clk);
    check(tx_empty == 1'b0, "R8", "tx_empty at window open", int'(tx_empty), 0);
    @(negedge clk);
    check(tx_empty == 1'b1, "R8", "tx_empty one clock later", int'(tx_empty), 1);
    wait_frames(7);

    // R6: second byte written during first frame, no idle gap
    send(8'h11);
    while (!buf_empty) @(negedge clk);
    send(8'h22);
    wait_frames(9);
    check(last_gap == 0, "R6", "idle bits between frames", last_gap, 0);

    // R7: disable mid-frame, frame still completes
    send(8'h3C);
    wait_start();
    set_ctrl(8'h02);
    wait_frames(10);
    check(buf_empty == 1'b1, "R7", "buffer after aborted-enable frame", int'(buf_empty), 1);

    // R3: CTS gating
    set_ctrl(8'h01);
    cts_n = 1'b1;
    send(8'h96);
    repeat (40) @(negedge clk);
    check(frames_done == 10 && buf_empty == 1'b0, "R3", "held by cts_n high", frames_done, 10);
    cts_n = 1'b0;
    wait_start();
    cts_n = 1'b1;                     // R7: raise mid-frame
    wait_frames(11);
    set_ctrl(8'h03);                  // pass mode, cts_n still high
    send(8'h69);
    wait_frames(12);
    check(frames_done == 12, "R3", "pass mode ignores cts_n", frames_done, 12);

    repeat (20) @(negedge clk);
    check(q.size() == 0, "R4", "scoreboard drained", q.size(), 0);
    check(irq_cnt == frames_done, "R9", "interrupt count", irq_cnt, frames_done);
    check(irq_long == 0, "R9", "multi-cycle interrupt", irq_long, 0);
    report();
    $finish;
  end

endmodule